// File: doc/BRIEF.md
# I2C Register Target with Auto-Advancing Pointer

This block is an I2C target that gives a controller access to a bank of 8-bit registers. The registers themselves sit outside the block. A transfer starts with the 7-bit target address. The top three bits of that address are fixed and the low four bits come from strap inputs. A write transfer then carries a command byte, which selects a register, followed by any number of data bytes. A read transfer returns bytes starting at the current pointer.

After every byte read or written, the pointer moves forward by one. The exception is the top register, 0x7F, where the pointer stays put. The MSB of the command byte is not used. A transfer made of a command byte alone moves the pointer when the STOP (or a repeated START) arrives. This lets a controller set the pointer and then read through a repeated START without losing the bus.

SCL and SDA are oversampled on the system clock. SDA is driven only low, through an enable output. The register bank port is a write strobe, a write address and data, and a combinational read path addressed by the same pointer. Clock stretching, general call and ten-bit addresses are not handled.

Top module: `i2c_reg_target`

## Requirements
- R1: The target acknowledges an address byte only when it equals {1,0,0, strap_i[3:0], R/W}, sent MSB first.
- R2: For a pointer value in 0x00..0x7E, the pointer advances by one after each data byte written or read.
- R3: With the pointer at 0x7F, it stays at 0x7F after each byte written or read.
- R4: Bit 7 of the command byte is ignored, so command 0x85 selects register 0x05.
- R5: Each written data byte produces a one-cycle reg_we_o pulse while SCL is high in that byte's acknowledge bit. The pulse carries the byte on reg_wdata_o and its register on reg_addr_o.
- R6: A write transfer made of a command byte alone, ended by STOP, sets the pointer to that command. A later read starts there.
- R7: A read that follows a command byte through a repeated START begins at the register that command selected.
- R8: Read data is driven MSB first from reg_rdata_i at reg_addr_o. After the controller answers a byte with NACK, SDA is released and stays released until STOP or START.
- R9: After an address byte that does not match, the target drives no ACK and makes no register write until the next START. The pointer is left unchanged.
- R10: While rst_ni is low and after its release, SDA is released, no write strobe is given, and the pointer is 0x00.
- R11: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 4 | Low four bits of the target address |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | When high, SDA is pulled low |
| reg_addr_o | output | 7 | Current register pointer |
| reg_wdata_o | output | 8 | Data byte to be written |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Content of the register at reg_addr_o |

## Verification
Some rules hold at every clock cycle, and the assertions check these:
- each write strobe lasts a single cycle and falls while SCL is high;
- a write at 0x00..0x7E moves the pointer by exactly one, and a write at 0x7F leaves it at 0x7F;
- the SDA enable never changes while SCL is high.

Other rules depend on whole bus transfers, and only the bench scenarios can show them:
- address matching against the straps;
- the command MSB being dropped;
- a command-only transfer landing on STOP;
- a repeated-START read using the new pointer;
- NACK release;
- a foreign address writing nothing.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_s, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SH_W-2:0], scl_i};
      sda_sh <= {sda_sh[SH_W-2:0], sda_i};
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign scl_p = scl_sh[SYNC_STAGES];
  assign sda_s = sda_sh[SYNC_STAGES-1];
  assign sda_p = sda_sh[SYNC_STAGES];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] PTR_TOP = '1;

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_val_i;
    end else if (step_i && ptr_q != PTR_TOP) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int              AW      = 7,
  parameter int              DW      = 8,
  parameter int              STRAP_W = 4,
  parameter logic [AW-STRAP_W-1:0] ADDR_HI = 3'b100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               sda_s_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [DW-1:0]      rdata_i,
  output logic               sda_oe_o,
  output logic               we_o,
  output logic [DW-1:0]      wdata_o,
  output logic               ptr_load_o,
  output logic [AW-1:0]      ptr_load_val_o,
  output logic               ptr_step_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

  tgt_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    rx_q, tx_q;
  logic [AW-1:0]    cmd_q;
  logic             pend_q, rw_q, nack_q;
  logic             rx_phase;

  assign rx_phase = (st_q == ST_ADDR) || (st_q == ST_CMD) || (st_q == ST_WDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      cmd_q  <= '0;
      pend_q <= 1'b0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      if (ptr_load_o) pend_q <= 1'b0;
      if (start_i) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
      end else if (rx_phase && scl_rise_i) begin
        rx_q  <= {rx_q[DW-2:0], sda_s_i};
        cnt_q <= cnt_q + 1'b1;
      end else if (rx_phase && scl_fall_i && cnt_q == CNT_FULL) begin
        unique case (st_q)
          ST_ADDR: begin
            rw_q <= rx_q[0];
            st_q <= (rx_q[DW-1:1] == {ADDR_HI, strap_i}) ? ST_ADDR_ACK : ST_SKIP;
          end
          ST_CMD:  st_q <= ST_CMD_ACK;
          default: st_q <= ST_WDATA_ACK;
        endcase
      end else begin
        unique case (st_q)
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              st_q <= ST_RDATA;
              tx_q <= rdata_i;
            end else begin
              st_q <= ST_CMD;
            end
          end
          ST_CMD_ACK: begin
            if (scl_rise_i) begin
              cmd_q  <= rx_q[AW-1:0];  // command MSB dropped
              pend_q <= 1'b1;
            end
            if (scl_fall_i) begin
              st_q  <= ST_WDATA;
              cnt_q <= '0;
            end
          end
          ST_WDATA_ACK: if (scl_fall_i) begin
            st_q  <= ST_WDATA;
            cnt_q <= '0;
          end
          ST_RDATA: if (scl_fall_i) begin
            if (cnt_q == CNT_LAST) begin
              st_q <= ST_RDATA_ACK;
            end else begin
              tx_q  <= {tx_q[DW-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise_i) nack_q <= sda_s_i;
            if (scl_fall_i) begin
              if (nack_q) begin
                st_q <= ST_SKIP;
              end else begin
                st_q  <= ST_RDATA;
                tx_q  <= rdata_i;
                cnt_q <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // a pending command lands on STOP, repeated START, or the first data bit
  assign ptr_load_o     = pend_q & (start_i | stop_i |
                          (st_q == ST_WDATA && scl_rise_i && cnt_q == '0));
  assign ptr_load_val_o = cmd_q;
  assign ptr_step_o     = scl_rise_i & ((st_q == ST_WDATA_ACK) | (st_q == ST_RDATA_ACK));
  assign we_o           = scl_rise_i & (st_q == ST_WDATA_ACK);
  assign wdata_o        = rx_q;

  always_comb begin
    unique case (st_q)
      ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
      ST_RDATA:                              sda_oe_o = ~tx_q[DW-1];
      default:                               sda_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int              AW      = 7,
  parameter int              DW      = 8,
  parameter int              STRAP_W = 4,
  parameter logic [AW-STRAP_W-1:0] ADDR_HI = 3'b100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [AW-1:0]      reg_addr_o,
  output logic [DW-1:0]      reg_wdata_o,
  output logic               reg_we_o,
  input  logic [DW-1:0]      reg_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic ptr_load, ptr_step;
  logic [AW-1:0] ptr_load_val;

  i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_tgt_fsm #(.AW(AW), .DW(DW), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .strap_i        (strap_i),
    .sda_s_i        (sda_s),
    .scl_rise_i     (scl_rise),
    .scl_fall_i     (scl_fall),
    .start_i        (start),
    .stop_i         (stop),
    .rdata_i        (reg_rdata_i),
    .sda_oe_o       (sda_oe_o),
    .we_o           (reg_we_o),
    .wdata_o        (reg_wdata_o),
    .ptr_load_o     (ptr_load),
    .ptr_load_val_o (ptr_load_val),
    .ptr_step_o     (ptr_step)
  );

  i2c_ptr_unit #(.AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_load_val),
    .step_i     (ptr_step),
    .ptr_o      (reg_addr_o)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_addr_o
);
  localparam logic [AW-1:0] TOP = '1;

  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);  // R5

  AST_WE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> scl_i);  // R5

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o != TOP) |=> reg_addr_o == AW'($past(reg_addr_o) + 1'b1));  // R2

  AST_PTR_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o == TOP) |=> reg_addr_o == TOP);  // R3

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);  // R11
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int QT = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] strap = 4'h5;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0]  bank [128];
  logic [7:0]  model_mem [128];
  logic [14:0] exp_q [$];
  logic [6:0]  exp_ptr = '0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .strap_i     (strap),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata)
  );

  assign reg_rdata = bank[reg_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes and applies them to the bank
  always @(negedge clk) begin
    if (rst_ni && reg_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected write", {17'd0, reg_addr, reg_wdata}, 32'd0);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R5 write addr/data", {17'd0, reg_addr, reg_wdata}, {17'd0, e});
      end
      bank[reg_addr] <= reg_wdata;
    end
  end

  task automatic q();
    repeat (QT) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    b = sda_line; q();
    scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  function automatic logic [6:0] nxt(input logic [6:0] a);
    return (a == 7'h7F) ? a : a + 7'd1;
  endfunction

  function automatic logic [7:0] addr_byte(input logic rw);
    return {3'b100, strap, rw};
  endfunction

  // driver: write transfer, n data bytes (n == 0 is command only)
  task automatic write_seq(input logic [7:0] cmd, input int n, input logic [7:0] base, input string req);
    logic ak;
    logic [6:0] a;
    logic [7:0] d;
    a = cmd[6:0];
    bus_start();
    send_byte(addr_byte(1'b0), ak);
    chk(ak, "R1 address ack", ak, 1);
    send_byte(cmd, ak);
    chk(ak, "R1 command ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      d = base + 8'(k * 8'h11);
      exp_q.push_back({a, d});
      model_mem[a] = d;
      send_byte(d, ak);
      chk(ak, req, ak, 1);
      a = nxt(a);
    end
    bus_stop();
    exp_ptr = a;
    q();
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // driver: read transfer, optionally setting the pointer via repeated START
  task automatic read_seq(input bit set, input logic [7:0] cmd, input int n, input string req);
    logic ak;
    logic [7:0] d;
    bus_start();
    if (set) begin
      send_byte(addr_byte(1'b0), ak);
      send_byte(cmd, ak);
      bus_rstart();
      exp_ptr = cmd[6:0];
    end
    send_byte(addr_byte(1'b1), ak);
    chk(ak, "R1 read address ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k != n - 1);
      chk(d == model_mem[exp_ptr], req, d, model_mem[exp_ptr]);
      exp_ptr = nxt(exp_ptr);
    end
    repeat (3 * QT) begin
      @(negedge clk);
      if (sda_oe) break;
    end
    chk(!sda_oe, "R8 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ak;
    for (int i = 0; i < 128; i++) begin
      bank[i] = 8'(i * 7 + 3);
      model_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    chk(!sda_oe && !reg_we, "R10 reset outputs", {sda_oe, reg_we}, 0);
    rst_ni = 1'b1;
    q();
    chk(reg_addr == 7'h00, "R10 pointer after reset", reg_addr, 0);
    read_seq(1'b0, 8'h00, 1, "R10 first read from 0x00");

    write_seq(8'h05, 3, 8'hA1, "R2 incrementing write");
    write_seq(8'h7E, 3, 8'h11, "R3 saturating write");
    chk(reg_addr == 7'h7F, "R3 pointer held at top", reg_addr, 7'h7F);
    write_seq(8'h85, 1, 8'h44, "R4 command MSB ignored");
    chk(bank[5] == 8'h44, "R4 register 0x05", bank[5], 8'h44);

    write_seq(8'h10, 0, 8'h00, "R6 command only");
    chk(reg_addr == 7'h10, "R6 pointer at STOP", reg_addr, 7'h10);
    read_seq(1'b0, 8'h00, 2, "R6 read after command-only");

    read_seq(1'b1, 8'h20, 3, "R7 repeated-start read");
    read_seq(1'b0, 8'h00, 1, "R2 read increments pointer");
    read_seq(1'b1, 8'h7F, 2, "R3 read saturates");

    // foreign address: strap 5, address 0x46
    bus_start();
    send_byte({3'b100, 4'h6, 1'b0}, ak);
    chk(!ak, "R9 no ack on foreign address", ak, 0);
    send_byte(8'h03, ak);
    chk(!ak, "R9 no ack on following byte", ak, 0);
    send_byte(8'h77, ak);
    chk(!ak && !sda_oe, "R9 ignored data byte", ak, 0);
    bus_stop();
    chk(reg_addr == 7'h7F, "R9 pointer unchanged", reg_addr, 7'h7F);
    read_seq(1'b0, 8'h00, 1, "R9 read after foreign transfer");

    strap = 4'hA;
    q();
    write_seq(8'h30, 2, 8'h5A, "R1 new strap value");
    chk(bank[6'h31] == 8'h6B, "R1 second byte stored", bank[6'h31], 8'h6B);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule